// File: doc/BRIEF.md
# Tap Position Store Controller

This block decides when the current tap position of a digitally stepped potentiometer is saved to non-volatile memory and restores it after reset. During reset it samples a strap pin that doubles later as a store button: a low level selects automatic store and a high level selects manual store. At the first clock after reset it presents the recalled memory value to the position counter. If the memory reports a blank word, it presents mid-scale instead.

In automatic mode, each debounced button activity pulse from the position logic restarts an inactivity timer. When the timer runs out, the current position is written once. The next write needs new activity. In manual mode, the same pin is debounced as a push button. While it is held low the position logic is frozen through the hold output. A debounced release starts a write. Writes use a single-cycle strobe and a busy input from the memory. All stimulus that arrives while a write is in flight is dropped.

Top module: `tap_store_ctrl`

## Requirements
- R1: The strap pin level during reset selects the mode: low gives automatic store, high gives manual store. In manual mode, button activity never starts a write.
- R2: In the first cycle after reset is released, `load_o` is high for exactly one cycle. `load_val_o` then carries `nv_rd_data_i` when `nv_rd_valid_i` is high.
- R3: When `nv_rd_valid_i` is low at that point, `load_val_o` is mid-scale, 2^(POS_W-1), which is 8 for a 4-bit position.
- R4: In automatic mode, `nv_wr_o` rises exactly IDLE_CYC+1 clock edges after the edge that samples the last `btn_evt_i` pulse. `nv_wr_data_o` equals `pos_i` at that moment. A new pulse before expiry restarts the count.
- R5: After an automatic write has completed, no further write occurs until a new activity pulse is seen.
- R6: In manual mode, a pin low period of at least DEB_CYC cycles followed by a return high starts one write of `pos_i`. A low period shorter than DEB_CYC cycles starts nothing.
- R7: In manual mode, `hold_o` is high while the debounced pin is low. It falls once the pin is high again and any write has finished.
- R8: In automatic mode, pin activity after reset has no effect: it causes no hold and no write.
- R9: `nv_wr_o` lasts one cycle and is never raised while `nv_busy_i` is high. `hold_o` stays high from the strobe until busy has fallen.
- R10: Activity pulses and pin releases that arrive while a write is in progress are ignored, and no later write results from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_n_i | input | 1 | Strap level at reset; manual store button afterwards (active low) |
| btn_evt_i | input | 1 | One-cycle pulse per debounced button step |
| pos_i | input | POS_W | Current tap position |
| nv_rd_data_i | input | POS_W | Recalled memory word |
| nv_rd_valid_i | input | 1 | Recalled word is valid (low for blank memory) |
| nv_busy_i | input | 1 | Memory write cycle in progress |
| nv_wr_o | output | 1 | Single-cycle write strobe |
| nv_wr_data_o | output | POS_W | Word to be written |
| load_o | output | 1 | Load pulse to the position counter after reset |
| load_val_o | output | POS_W | Value to load |
| hold_o | output | 1 | Freezes the position logic |

## Verification
The bench builds the block with IDLE_CYC=40 and DEB_CYC=6 in place of second- and millisecond-scale counts. These small values let it sweep every one of the 16 recall words, every position for both automatic and manual writes, and the exact expiry edge of the timer, all within a short run. A bench memory model holds busy for ten cycles. This makes the window in which stray pulses and releases must be dropped long enough to probe.

// File: rtl/tap_store_pkg.sv
package tap_store_pkg;

  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_STROBE = 3'd2,
    ST_ACK    = 3'd3,
    ST_BUSY   = 3'd4
  } wr_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tss_pin_filter.sv
module tss_pin_filter #(
  parameter int unsigned DEB_CYC = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  import tap_store_pkg::*;

  localparam int unsigned CW = cnt_width(DEB_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

  logic          sync_a_q, sync_b_q;
  logic          level_q, rise_q;
  logic [CW-1:0] cnt_q;
  logic          differs, settle;

  assign differs = (sync_b_q != level_q);
  assign settle  = differs && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a_q <= 1'b1;
      sync_b_q <= 1'b1;
    end else begin
      sync_a_q <= pin_i;
      sync_b_q <= sync_a_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= settle && sync_b_q;
      if (!differs) begin
        cnt_q <= '0;
      end else if (settle) begin
        cnt_q   <= '0;
        level_q <= sync_b_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
endmodule

// File: rtl/tss_idle_timer.sv
module tss_idle_timer #(
  parameter int unsigned IDLE_CYC = 200000000
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  output logic fire_o
);
  import tap_store_pkg::*;

  localparam int unsigned CW = cnt_width(IDLE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(IDLE_CYC - 1);

  logic          armed_q, fire_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (act_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q) begin
        if (cnt_q == CNT_LAST) begin
          armed_q <= 1'b0;
          fire_q  <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/tss_write_seq.sv
module tss_write_seq #(
  parameter int unsigned POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             busy_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] rd_data_i,
  input  logic             rd_valid_i,
  output logic             wr_o,
  output logic [POS_W-1:0] wr_data_o,
  output logic             active_o,
  output logic             load_o,
  output logic [POS_W-1:0] load_val_o
);
  import tap_store_pkg::*;

  localparam logic [POS_W-1:0] MID_POS = POS_W'(1) << (POS_W - 1);

  wr_state_t        st_q, st_d;
  logic             pend_q, start;
  logic [POS_W-1:0] data_q, load_val_q;
  logic             load_q;

  assign start = (st_q == ST_IDLE) && (trig_i || pend_q) && !busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT:   st_d = ST_IDLE;
      ST_IDLE:   if (start) st_d = ST_STROBE;
      ST_STROBE: st_d = ST_ACK;
      ST_ACK:    if (busy_i) st_d = ST_BUSY;
      ST_BUSY:   if (!busy_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_BOOT;
      pend_q     <= 1'b0;
      data_q     <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      st_q   <= st_d;
      load_q <= (st_q == ST_BOOT);
      if (st_q == ST_BOOT) begin
        load_val_q <= rd_valid_i ? rd_data_i : MID_POS;
      end
      if (st_q == ST_IDLE) begin
        pend_q <= (pend_q || trig_i) && busy_i;
      end else begin
        pend_q <= 1'b0;
      end
      if (start) begin
        data_q <= pos_i;
      end
    end
  end

  assign wr_o       = (st_q == ST_STROBE);
  assign wr_data_o  = data_q;
  assign active_o   = (st_q != ST_IDLE);
  assign load_o     = load_q;
  assign load_val_o = load_val_q;
endmodule

// File: rtl/tap_store_ctrl.sv
module tap_store_ctrl #(
  parameter int unsigned POS_W    = 4,
  parameter int unsigned IDLE_CYC = 200000000,
  parameter int unsigned DEB_CYC  = 1500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_n_i,
  input  logic             btn_evt_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] nv_rd_data_i,
  input  logic             nv_rd_valid_i,
  input  logic             nv_busy_i,
  output logic             nv_wr_o,
  output logic [POS_W-1:0] nv_wr_data_o,
  output logic             load_o,
  output logic [POS_W-1:0] load_val_o,
  output logic             hold_o
);

  logic auto_q;
  logic pin_level, pin_rise;
  logic timer_fire, seq_active;
  logic act_ok, trig;
  logic pin_lock;

  always_ff @(posedge clk) begin
    if (rst) auto_q <= ~strap_n_i;
  end

  tss_pin_filter #(.DEB_CYC(DEB_CYC)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (strap_n_i),
    .level_o (pin_level),
    .rise_o  (pin_rise)
  );

  assign act_ok = btn_evt_i && auto_q && !seq_active;

  tss_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .act_i  (act_ok),
    .fire_o (timer_fire)
  );

  assign trig = auto_q ? timer_fire : pin_rise;

  tss_write_seq #(.POS_W(POS_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig),
    .busy_i     (nv_busy_i),
    .pos_i      (pos_i),
    .rd_data_i  (nv_rd_data_i),
    .rd_valid_i (nv_rd_valid_i),
    .wr_o       (nv_wr_o),
    .wr_data_o  (nv_wr_data_o),
    .active_o   (seq_active),
    .load_o     (load_o),
    .load_val_o (load_val_o)
  );

  assign pin_lock = !auto_q && !pin_level;
  assign hold_o   = seq_active || pin_lock;
endmodule

// File: rtl/tap_store_chk.sv
module tap_store_chk #(
  parameter int unsigned POS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             nv_busy_i,
  input logic [POS_W-1:0] pos_i,
  input logic             nv_wr_o,
  input logic [POS_W-1:0] nv_wr_data_o,
  input logic             load_o,
  input logic             hold_o
);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    nv_wr_o |=> !nv_wr_o);

  p_no_strobe_busy_r9: assert property (@(posedge clk) disable iff (rst)
    nv_busy_i |-> !nv_wr_o);

  p_hold_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    nv_wr_o |=> hold_o);

  p_data_captured_r4: assert property (@(posedge clk) disable iff (rst)
    nv_wr_o |-> (nv_wr_data_o == $past(pos_i)));

  p_load_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(rst, 2));

  p_load_single_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

endmodule

bind tap_store_ctrl tap_store_chk #(.POS_W(POS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .nv_busy_i    (nv_busy_i),
  .pos_i        (pos_i),
  .nv_wr_o      (nv_wr_o),
  .nv_wr_data_o (nv_wr_data_o),
  .load_o       (load_o),
  .hold_o       (hold_o)
);

// File: tb/test_tap_store_ctrl.sv
`timescale 1ns/1ps
module test_tap_store_ctrl;
  localparam int POS_W = 4;
  localparam int IDLE  = 40;
  localparam int DEB   = 6;
  localparam int BLEN  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_n = 1'b1;
  logic evt = 1'b0;
  logic [POS_W-1:0] pos = '0;
  logic [POS_W-1:0] rd_data = '0;
  logic rd_valid = 1'b1;
  logic busy;
  logic wr;
  logic [POS_W-1:0] wr_data, load_val;
  logic load, hold;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [POS_W-1:0] mem_word = '0;
  int busy_cnt = 0;

  always #10 clk = ~clk;

  tap_store_ctrl #(.POS_W(POS_W), .IDLE_CYC(IDLE), .DEB_CYC(DEB)) i_tap_store_ctrl (
    .clk(clk), .rst(rst), .strap_n_i(strap_n), .btn_evt_i(evt), .pos_i(pos),
    .nv_rd_data_i(rd_data), .nv_rd_valid_i(rd_valid), .nv_busy_i(busy),
    .nv_wr_o(wr), .nv_wr_data_o(wr_data), .load_o(load), .load_val_o(load_val),
    .hold_o(hold)
  );

  // memory model: busy starts the edge after the strobe
  assign busy = (busy_cnt != 0);
  always_ff @(posedge clk) begin
    if (wr) begin
      mem_word <= wr_data;
      busy_cnt <= BLEN;
      wr_cnt   <= wr_cnt + 1;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_free();
    int guard = 0;
    while ((hold || busy) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic do_reset(input logic strap, input logic valid, input int val);
    @(negedge clk);
    rst = 1'b1; strap_n = strap; rd_valid = valid; rd_data = POS_W'(val);
    cycles(3);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R2 load pulse", int'(load), 1);
    chk(valid ? "R2 load value" : "R3 blank load value", int'(load_val), valid ? val : 8);
    @(posedge clk); #1;
    chk("R2 load single", int'(load), 0);
  endtask

  // returns edges from the evt-sampling edge to the strobe
  task automatic pulse_and_measure(output int n);
    @(negedge clk); evt = 1'b1;
    @(posedge clk); #1; evt = 1'b0;
    n = 0;
    while (!wr && n < IDLE + 20) begin
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n, w0;
    // R2/R3: sweep every recall word and a blank memory
    for (int v = 0; v < 16; v++) do_reset(1'b0, 1'b1, v);
    do_reset(1'b0, 1'b0, 3);
    chk("R7 hold idle after reset", int'(hold), 0);

    // R4: automatic write of every position, exact expiry edge
    for (int p = 0; p < 16; p++) begin
      pos = POS_W'(p);
      w0 = wr_cnt;
      pulse_and_measure(n);
      chk("R4 expiry edge", n, IDLE + 1);
      chk("R4 write data", int'(wr_data), p);
      @(posedge clk); #1;
      chk("R9 strobe width", int'(wr), 0);
      chk("R9 hold during write", int'(hold), 1);
      // R10: activity during the write is dropped
      cycles(3);
      chk("R9 busy seen", int'(busy), 1);
      evt = 1'b1; @(negedge clk); evt = 1'b0;
      wait_free();
      chk("R9 hold released", int'(hold), 0);
      chk("R4 memory word", int'(mem_word), p);
      cycles(2 * IDLE);
      chk("R5 R10 no extra write", wr_cnt - w0, 1);
    end

    // R4: restart before expiry
    pos = 4'd11;
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    cycles(IDLE / 2);
    chk("R4 no early write", int'(wr), 0);
    pulse_and_measure(n);
    chk("R4 restarted expiry", n, IDLE + 1);
    wait_free();

    // R8: pin ignored in automatic mode
    w0 = wr_cnt;
    strap_n = 1'b1; cycles(4);
    strap_n = 1'b0; cycles(DEB + 10);
    chk("R8 no hold from pin", int'(hold), 0);
    strap_n = 1'b1; cycles(DEB + 20);
    chk("R8 no write from pin", wr_cnt - w0, 0);

    // manual mode
    do_reset(1'b1, 1'b1, 5);
    w0 = wr_cnt;
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    cycles(IDLE + 20);
    chk("R1 no auto write in manual", wr_cnt - w0, 0);

    for (int p = 0; p < 16; p++) begin
      pos = POS_W'(15 - p);
      w0 = wr_cnt;
      strap_n = 1'b0; cycles(DEB + 8);
      chk("R7 hold while pin low", int'(hold), 1);
      chk("R6 no write while low", wr_cnt - w0, 0);
      strap_n = 1'b1; cycles(DEB + 6);
      chk("R6 write on release", wr_cnt - w0, 1);
      chk("R6 manual data", int'(mem_word), 15 - p);
      wait_free();
      chk("R7 hold falls", int'(hold), 0);
    end

    // R6: short press
    w0 = wr_cnt;
    strap_n = 1'b0; cycles(DEB - 3);
    strap_n = 1'b1; cycles(DEB + 20);
    chk("R6 short press ignored", wr_cnt - w0, 0);
    chk("R7 no hold from glitch", int'(hold), 0);

    // R10: a release during a write is dropped
    w0 = wr_cnt;
    strap_n = 1'b0; cycles(DEB + 8);
    strap_n = 1'b1;
    while (!busy) @(negedge clk);
    strap_n = 1'b0; cycles(2);
    strap_n = 1'b1;
    wait_free();
    cycles(DEB + 20);
    chk("R10 release during write dropped", wr_cnt - w0, 1);

    summary();
  end
endmodule